// File: doc/BRIEF.md
# Segment Identifier Scrambler

This block turns an address-space segment request into a scrambled 36-bit virtual segment identifier. A request carries a privilege-space select (kernel or user), a context number and an effective segment number. The block first forms a 36-bit proto identifier from these inputs. It then multiplies the proto value by a fixed 28-bit prime and reduces the product modulo 2^36 − 1. The result spreads segments evenly across a hashed translation table.

The reduction needs no divider. The modulus is one less than a power of two, so the high half of the product is added onto the low half. A single increment-and-carry correction then brings the sum into range. The work is split into three registered stages: multiply, fold and correct. The unit accepts one request per cycle and delivers each result exactly three cycles after it is accepted, together with a valid strobe.

Proto values that the scramble cannot map are reserved. When one of them arrives, the block flags an error and returns zero in place of a result.

Top module: `vsid_scrambler`

## Requirements
- R1: With `in_kernel` = 1, the proto value equals the full 36-bit `in_esid`.
- R2: With `in_kernel` = 0, the proto value is `in_context` (19 bits) placed at bits 34..16, `in_esid[15:0]` at bits 15..0, and bit 35 zero. `in_esid[35:16]` has no effect on the result.
- R3: For a proto value that is not reserved, `out_vsid` = (proto × 200730139) mod (2^36 − 1), and `out_err` = 0.
- R4: A proto value of all ones (0xFFFFFFFFF) is reserved. The block gives `out_err` = 1 and `out_vsid` = 0.
- R5: A proto value whose bits 35..34 are 2'b10 is reserved. The block gives `out_err` = 1 and `out_vsid` = 0.
- R6: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` rises three edges later, for one cycle per request. Back-to-back requests produce back-to-back results in order.
- R7: While `rst_n` is low, `in_ready` and `out_valid` are 0. `in_ready` is 1 from the first edge after reset is released.
- R8: A valid result never equals 2^36 − 1. The boundary inputs give these values: proto 0 gives 0, and proto 0xFFFFFFFFE gives a regular result with no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_kernel | input | 1 | 1 = kernel space, 0 = user space |
| in_context | input | 19 | User context number |
| in_esid | input | 36 | Effective segment number |
| out_valid | output | 1 | Result strobe |
| out_vsid | output | 36 | Scrambled segment identifier, zero on error |
| out_err | output | 1 | Reserved proto value seen |

## Verification
Kernel requests with random segment numbers exercise the full 36-bit multiply and fold. Values near the modulus, such as 0xFFFFFFFFE, exercise the carry correction, which only acts when the folded sum reaches 2^36 − 1. User requests carry random junk in the upper segment-number bits. Checking them against the reference shows whether only the low 16 bits are taken, and whether the context is placed correctly. The three reserved patterns are all ones, the bottom of the 2'b10 range and the top of the 2'b10 range. These are mixed with neighbours in the 2'b01 and 2'b11 ranges that are not reserved, which separates a correct reserved-range decode from one that is too wide or too narrow. Back-to-back bursts alternate with gapped traffic to confirm the fixed latency and one-per-cycle ordering.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
  localparam int SEG_W      = 36;
  localparam int CTX_W      = 19;
  localparam int USR_W      = 16;
  localparam int MULT_W     = 28;
  localparam int PROD_W     = SEG_W + MULT_W;
  localparam int FOLD_W     = SEG_W + 1;
  localparam logic [MULT_W-1:0] MULT_K = 28'd200730139;
  localparam logic [SEG_W-1:0]  MOD_V  = {SEG_W{1'b1}};

  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [PROD_W-1:0] prod_t;
  typedef logic [FOLD_W-1:0] fold_t;

  function automatic seg_t build_proto(input logic kern,
                                       input logic [CTX_W-1:0] ctx,
                                       input seg_t esid);
    seg_t p;
    if (kern) p = esid;
    else      p = {{(SEG_W-CTX_W-USR_W){1'b0}}, ctx, esid[USR_W-1:0]};
    return p;
  endfunction

  function automatic logic proto_reserved(input seg_t p);
    return (p == MOD_V) || (p[SEG_W-1:SEG_W-2] == 2'b10);
  endfunction

  function automatic fold_t fold_prod(input prod_t pr);
    fold_t hi, lo;
    hi = {{(FOLD_W-(PROD_W-SEG_W)){1'b0}}, pr[PROD_W-1:SEG_W]};
    lo = {1'b0, pr[SEG_W-1:0]};
    return hi + lo;
  endfunction

  function automatic seg_t fix_fold(input fold_t x);
    logic [FOLD_W:0] inc;
    fold_t sum;
    inc = {1'b0, x} + {{FOLD_W{1'b0}}, 1'b1};
    sum = x + {{(FOLD_W-1){1'b0}}, inc[SEG_W]};
    return sum[SEG_W-1:0];
  endfunction
endpackage

// File: rtl/vsid_proto_build.sv
module vsid_proto_build
  import vsid_pkg::*;
(
  input  logic             kern,
  input  logic [CTX_W-1:0] ctx,
  input  seg_t             esid,
  output seg_t             proto,
  output logic             resv
);
  always_comb begin
    proto = build_proto(kern, ctx, esid);
    resv  = proto_reserved(proto);
  end

  always_comb begin
    if (!kern) a_r2_user_top_clear: assert (proto[SEG_W-1] == 1'b0);
  end
endmodule

// File: rtl/vsid_mul_stage.sv
module vsid_mul_stage
  import vsid_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vin,
  input  seg_t  proto,
  input  logic  resv,
  output logic  vout,
  output prod_t prod,
  output logic  err
);
  prod_t prod_c;
  always_comb prod_c = prod_t'(proto) * prod_t'(MULT_K);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout <= 1'b0;
      prod <= '0;
      err  <= 1'b0;
    end else begin
      vout <= vin;
      if (vin) begin
        prod <= resv ? '0 : prod_c;
        err  <= resv;
      end
    end
  end

  a_r4_err_prod_zero: assert property (@(posedge clk) disable iff (!rst_n)
    vout && err |-> prod == '0);
endmodule

// File: rtl/vsid_fold_stage.sv
module vsid_fold_stage
  import vsid_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vin,
  input  prod_t prod,
  input  logic  ein,
  output logic  vout,
  output fold_t x,
  output logic  err
);
  localparam fold_t FOLD_MAX = fold_t'(MOD_V) + fold_t'({MULT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout <= 1'b0;
      x    <= '0;
      err  <= 1'b0;
    end else begin
      vout <= vin;
      if (vin) begin
        x   <= fold_prod(prod);
        err <= ein;
      end
    end
  end

  a_r3_fold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    vout |-> x <= FOLD_MAX);
endmodule

// File: rtl/vsid_fix_stage.sv
module vsid_fix_stage
  import vsid_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vin,
  input  fold_t x,
  input  logic  ein,
  output logic  vout,
  output seg_t  vsid,
  output logic  err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout <= 1'b0;
      vsid <= '0;
      err  <= 1'b0;
    end else begin
      vout <= vin;
      if (vin) begin
        vsid <= ein ? '0 : fix_fold(x);
        err  <= ein;
      end
    end
  end

  a_r8_never_modulus: assert property (@(posedge clk) disable iff (!rst_n)
    vout && !err |-> vsid != MOD_V);
  a_r4_err_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    vout && err |-> vsid == '0);
endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler
  import vsid_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_kernel,
  input  logic [18:0] in_context,
  input  logic [35:0] in_esid,
  output logic        out_valid,
  output logic [35:0] out_vsid,
  output logic        out_err
);
  logic  ready_q;
  logic  accept;
  seg_t  proto;
  logic  resv;
  logic  m_v, m_e, f_v, f_e;
  prod_t m_prod;
  fold_t f_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  vsid_proto_build u_proto (
    .kern(in_kernel), .ctx(in_context), .esid(in_esid),
    .proto(proto), .resv(resv)
  );

  vsid_mul_stage u_mul (
    .clk(clk), .rst_n(rst_n), .vin(accept), .proto(proto), .resv(resv),
    .vout(m_v), .prod(m_prod), .err(m_e)
  );

  vsid_fold_stage u_fold (
    .clk(clk), .rst_n(rst_n), .vin(m_v), .prod(m_prod), .ein(m_e),
    .vout(f_v), .x(f_x), .err(f_e)
  );

  vsid_fix_stage u_fix (
    .clk(clk), .rst_n(rst_n), .vin(f_v), .x(f_x), .ein(f_e),
    .vout(out_valid), .vsid(out_vsid), .err(out_err)
  );

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(accept, 3));
  a_r6_err_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_err == $past(resv, 3));
  a_r7_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
endmodule

// File: tb/tb_vsid_scrambler.sv
module tb_vsid_scrambler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_kernel = 1'b0;
  logic [18:0] in_context = '0;
  logic [35:0] in_esid = '0;
  logic        out_valid;
  logic [35:0] out_vsid;
  logic        out_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic [35:0] vsid;
    logic        err;
    int          t;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vsid_scrambler dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kernel(in_kernel), .in_context(in_context), .in_esid(in_esid),
    .out_valid(out_valid), .out_vsid(out_vsid), .out_err(out_err)
  );

  function automatic logic [35:0] ref_scr(input logic [35:0] p);
    logic [63:0] big;
    big = {28'd0, p} * 64'd200730139;
    return 36'(big % 64'h0000000FFFFFFFFF);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic k, input logic [18:0] c,
                      input logic [35:0] e, input string req);
    logic [35:0] p;
    logic        rv;
    exp_t        it;
    @(negedge clk);
    in_valid = 1'b1; in_kernel = k; in_context = c; in_esid = e;
    p  = k ? e : {1'b0, c, e[15:0]};
    rv = (p == 36'hFFFFFFFFF) || (p[35:34] == 2'b10);
    it.vsid = rv ? 36'd0 : ref_scr(p);
    it.err  = rv;
    it.t    = cyc + 3;
    it.req  = req;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(0, "R6", "unexpected result", {63'd0, out_valid}, 64'd0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(out_vsid == it.vsid, it.req, "vsid", {28'd0, out_vsid}, {28'd0, it.vsid});
        check(out_err == it.err, it.req, "err", {63'd0, out_err}, {63'd0, it.err});
        check(cyc == it.t, "R6", "latency", 64'(cyc), 64'(it.t));
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R7", "ready in reset", {63'd0, in_ready}, 64'd0);
    check(out_valid == 1'b0, "R7", "valid in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R7", "ready after reset", {63'd0, in_ready}, 64'd1);

    // Boundaries: R8 zero and just below modulus, R4/R5 reserved, neighbours
    send(1'b1, '0, 36'h000000000, "R8");
    send(1'b1, '0, 36'hFFFFFFFFE, "R8");
    send(1'b1, '0, 36'hFFFFFFFFF, "R4");
    send(1'b1, '0, 36'h800000000, "R5");
    send(1'b1, '0, 36'hBFFFFFFFF, "R5");
    send(1'b1, '0, 36'h7FFFFFFFF, "R3");
    send(1'b1, '0, 36'hC00000000, "R1");
    send(1'b1, '0, 36'h000000001, "R3");
    idle(5);

    // R1 kernel random, back-to-back
    for (int i = 0; i < 200; i++)
      send(1'b1, '0, {4'($urandom), 32'($urandom)}, "R1");
    idle(4);

    // R2 user with junk upper bits, gapped
    for (int i = 0; i < 150; i++) begin
      send(1'b0, 19'($urandom), {4'($urandom), 32'($urandom)}, "R2");
      if (i % 3 == 0) idle(1 + (i % 4));
    end
    send(1'b0, 19'h7FFFF, 36'hFFFFFFFFF, "R2");
    send(1'b0, 19'h00000, 36'hFFFF0000, "R2");

    // mixed stream incl. reserved, R3/R5
    for (int i = 0; i < 200; i++)
      send(1'($urandom), 19'($urandom),
           {2'($urandom), 2'($urandom), 32'($urandom)}, "R3");
    idle(6);
    check(sb.size() == 0, "R6", "results outstanding", 64'(sb.size()), 64'd0);
    check(out_valid == 1'b0, "R6", "valid after drain", {63'd0, out_valid}, 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule